// File: doc/BRIEF.md
# Whole-Array Erase and Blank-Check Sequencer

This controller runs the closed-loop erase procedure of a byte-wide reprogrammable memory array whose erased bits read as one. There is no preprogramming: a start request goes straight into an erase pulse, and the pulse is held for a fixed number of clock cycles. The controller then reads the array back byte by byte through a read port and checks each byte for the blank value, all ones. Programming can only clear bits, so any zero bit marks a byte that is not yet erased.

Verification stops at the first byte that still holds a zero. Its address is saved, and the whole array gets another pulse. The next sweep starts at the saved address, wraps from the top address to zero and stops just before the saved address, so that every byte has been checked after the last pulse. The result is pass when a sweep finds no bad byte. It is fail when a byte is still bad after the pulse budget has been used.

The read port is a request/response stream. A request (address) is offered with `rd_valid_o`. It is accepted in a cycle where `rd_ready_i` is high, and the memory may hold it back for any number of cycles. Exactly one request is outstanding at a time, and the controller sends no new request until the response (`rsp_valid_i` with `rsp_data_i`) arrives. The controller always accepts a response in the waiting state, so the response path has no ready signal.

Top module: `erase_verify_seq`

## Requirements
- R1: After reset, busy_o, pass_o, fail_o, erase_pulse_o, hv_sel_o and rd_valid_o are all low. Whenever busy_o is low, neither erase_pulse_o nor rd_valid_o is high.
- R2: start_i sampled high while busy_o is low makes busy_o and erase_pulse_o high in the next cycle and clears pass_o and fail_o. No read is issued before that first pulse. start_i while busy_o is high has no effect.
- R3: Every erase pulse holds erase_pulse_o high for exactly PULSE_CYCLES consecutive cycles, and rd_valid_o is never high while erase_pulse_o is high.
- R4: The first verify sweep after a start requests address 0 first and then ascending addresses.
- R5: A byte counts as blank only when rsp_data_i is all ones (FFh). A byte with any zero bit, including only bit 7 clear, fails.
- R6: A failing byte ends the sweep at once, and another erase pulse follows (budget permitting).
- R7: After a failed sweep, the next sweep starts at the failing address, wraps from address 2^ADDR_W-1 to 0, and ends at the address just below the start.
- R8: pass_o goes high, and busy_o low, only after a whole sweep of 2^ADDR_W reads with no failing byte. pass_o stays high until the next start. busy_o, pass_o and fail_o are never high together.
- R9: At most MAX_PULSES pulses are given per start. A failing byte seen after pulse MAX_PULSES raises fail_o, with no further pulse.
- R10: While rd_valid_o is high and rd_ready_i is low, rd_valid_o stays high and rd_addr_o holds its value.
- R11: hv_sel_o, the programming-supply select status, is high exactly while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an erase procedure (ignored while busy) |
| busy_o | output | 1 | Procedure in progress |
| pass_o | output | 1 | Last procedure ended blank |
| fail_o | output | 1 | Last procedure ran out of pulses |
| hv_sel_o | output | 1 | Programming-supply select status |
| erase_pulse_o | output | 1 | Erase pulse to the array |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read request address |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | DATA_W | Read response byte |

## Verification
The hardest state to reach from the ports is a resumed sweep that has to wrap: a byte near the top address must fail after one pulse while lower bytes are already blank. The next sweep must then cross from the top address to zero and end just before the resume point. The bench's memory model gives each byte the number of pulses it needs before it reads blank. Directed cases place a slow byte at the top address, at the pulse-budget limit and one beyond it. Random cases mix per-byte pulse needs with random ready back-pressure and response latency.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PULSE   = 3'd1,
    ST_RD_REQ  = 3'd2,
    ST_RD_WAIT = 3'd3,
    ST_PASS    = 3'd4,
    ST_FAIL    = 3'd5
  } seq_state_e;

  function automatic logic is_active(input seq_state_e s);
    return (s == ST_PULSE) || (s == ST_RD_REQ) || (s == ST_RD_WAIT);
  endfunction

endpackage

// File: rtl/erase_pulse_timer.sv
module erase_pulse_timer #(
  parameter int PULSE_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYCLES - 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= RELOAD;
    end else if (run_i && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired_o = run_i && (remain_q == '0);
endmodule

// File: rtl/pulse_budget.sv
module pulse_budget #(
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic inc_i,
  output logic exhausted_o
);
  localparam int BW = $clog2(MAX_PULSES + 1);
  localparam logic [BW-1:0] LIMIT = BW'(MAX_PULSES);

  logic [BW-1:0] used_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (clear_i) begin
      used_q <= '0;
    end else if (inc_i && used_q != LIMIT) begin
      used_q <= used_q + 1'b1;
    end
  end

  assign exhausted_o = (used_q == LIMIT);
endmodule

// File: rtl/verify_addr_walker.sv
module verify_addr_walker #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic [ADDR_W-1:0] begin_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] origin_q;
  logic [ADDR_W-1:0] next_addr;

  // natural modulo wrap from the top address to zero
  assign next_addr = cur_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      origin_q <= '0;
    end else if (begin_i) begin
      cur_q    <= begin_addr_i;
      origin_q <= begin_addr_i;
    end else if (step_i) begin
      cur_q    <= next_addr;
    end
  end

  assign addr_o = cur_q;
  assign last_o = (next_addr == origin_q);
endmodule

// File: rtl/erase_verify_seq.sv
module erase_verify_seq #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 50,
  parameter int MAX_PULSES   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              hv_sel_o,
  output logic              erase_pulse_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i
);
  import erase_seq_pkg::*;

  localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] resume_q, resume_d;
  logic [ADDR_W-1:0] cur_addr;
  logic              sweep_last;
  logic              pulse_done;
  logic              budget_out;
  logic              timer_load, budget_clr, budget_inc;
  logic              walk_begin, walk_step;
  logic              active;
  logic              byte_blank;

  assign active     = is_active(state_q);
  assign byte_blank = (rsp_data_i == BLANK);

  erase_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (timer_load),
    .run_i     (state_q == ST_PULSE),
    .expired_o (pulse_done)
  );

  pulse_budget #(.MAX_PULSES(MAX_PULSES)) u_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (budget_clr),
    .inc_i       (budget_inc),
    .exhausted_o (budget_out)
  );

  verify_addr_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .begin_i      (walk_begin),
    .begin_addr_i (resume_q),
    .step_i       (walk_step),
    .addr_o       (cur_addr),
    .last_o       (sweep_last)
  );

  always_comb begin
    state_d    = state_q;
    resume_d   = resume_q;
    timer_load = 1'b0;
    budget_clr = 1'b0;
    budget_inc = 1'b0;
    walk_begin = 1'b0;
    walk_step  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (start_i) begin
          state_d    = ST_PULSE;
          resume_d   = '0;
          timer_load = 1'b1;
          budget_clr = 1'b1;
        end
      end
      ST_PULSE: begin
        if (pulse_done) begin
          state_d    = ST_RD_REQ;
          budget_inc = 1'b1;
          walk_begin = 1'b1;
        end
      end
      ST_RD_REQ: begin
        if (rd_ready_i) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (rsp_valid_i) begin
          if (byte_blank) begin
            if (sweep_last) begin
              state_d = ST_PASS;
            end else begin
              state_d   = ST_RD_REQ;
              walk_step = 1'b1;
            end
          end else begin
            resume_d = cur_addr;
            if (budget_out) begin
              state_d = ST_FAIL;
            end else begin
              state_d    = ST_PULSE;
              timer_load = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      resume_q <= '0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
    end
  end

  assign busy_o        = active;
  assign hv_sel_o      = active;
  assign pass_o        = (state_q == ST_PASS);
  assign fail_o        = (state_q == ST_FAIL);
  assign erase_pulse_o = (state_q == ST_PULSE);
  assign rd_valid_o    = (state_q == ST_RD_REQ);
  assign rd_addr_o     = cur_addr;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int ADDR_W       = 8,
  parameter int PULSE_CYCLES = 50,
  parameter int MAX_PULSES   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic              erase_pulse_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o
);
  int unsigned hi_len;
  int unsigned pulses;
  logic        pulse_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_len     <= 0;
      pulses     <= 0;
      pulse_prev <= 1'b0;
    end else begin
      pulse_prev <= erase_pulse_o;
      hi_len     <= erase_pulse_o ? hi_len + 1 : 0;
      if (start_i && !busy_o)                pulses <= 0;
      else if (erase_pulse_o && !pulse_prev) pulses <= pulses + 1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!erase_pulse_o && !rd_valid_o));

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && erase_pulse_o && !pass_o && !fail_o));

  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_prev && !erase_pulse_o) |-> (hi_len == PULSE_CYCLES));

  assert_no_read_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_pulse_o && rd_valid_o));

  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, pass_o, fail_o}));

  assert_pulse_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= MAX_PULSES);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));
endmodule

bind erase_verify_seq erase_seq_chk #(
  .ADDR_W(ADDR_W), .PULSE_CYCLES(PULSE_CYCLES), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .pass_o(pass_o), .fail_o(fail_o), .erase_pulse_o(erase_pulse_o),
  .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o)
);

// File: tb/erase_verify_seq_bench.sv
module erase_verify_seq_bench;
  localparam int AW    = 5;
  localparam int N     = 1 << AW;
  localparam int PCYC  = 20;
  localparam int MAXP  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, pass, fail, hv_sel, epulse, rd_valid;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rsp_valid = 1'b0;
  logic [7:0]    rsp_data = 8'h00;

  erase_verify_seq #(.ADDR_W(AW), .DATA_W(8), .PULSE_CYCLES(PCYC), .MAX_PULSES(MAXP)) u_erase_verify_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .pass_o(pass),
    .fail_o(fail), .hv_sel_o(hv_sel), .erase_pulse_o(epulse),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int need[N];
  logic [7:0] miss[N];
  int pulses_seen, reads_seen, hi_run, exp_addr, lat;
  bit pend, prev_pulse, read_in_pulse, hold_pend, mon_en;
  logic [AW-1:0] hold_addr, pend_addr;
  int ready_pct;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // memory model and stream monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
    if (mon_en) begin
      if (epulse && !prev_pulse) begin pulses_seen++; hi_run = 0; read_in_pulse = 0; end
      if (epulse) begin hi_run++; if (rd_valid) read_in_pulse = 1; end
      if (!epulse && prev_pulse) begin
        check(hi_run == PCYC, "R3 pulse length", hi_run, PCYC);
        check(!read_in_pulse, "R3 no read in pulse", read_in_pulse, 0);
      end
      prev_pulse = epulse;
      if (hold_pend) begin
        check(rd_valid && rd_addr == hold_addr, "R10 held request", int'(rd_addr), int'(hold_addr));
        hold_pend = 0;
      end
      if (rsp_valid) rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = (pulses_seen >= need[pend_addr]) ? 8'hFF : ~miss[pend_addr];
          exp_addr  = (rsp_data == 8'hFF) ? (int'(pend_addr) + 1) % N : int'(pend_addr);
          pend = 0;
        end else lat--;
      end
      rd_ready = (($urandom % 100) < ready_pct);
      if (rd_valid && rd_ready) begin
        check(int'(rd_addr) == exp_addr, "R4 R7 sweep address", int'(rd_addr), exp_addr);
        reads_seen++;
        pend = 1; pend_addr = rd_addr; lat = $urandom % 3;
      end else if (rd_valid) begin
        hold_pend = 1; hold_addr = rd_addr;
      end
    end
  end

  task automatic predict(output int np, output bit ok, output int nr);
    int p = 1, s = 0;
    bit done = 0;
    nr = 0; ok = 0; np = 0;
    while (!done) begin
      int bad = -1;
      for (int i = 0; i < N; i++) begin
        int a = (s + i) % N;
        nr++;
        if (need[a] > p) begin bad = a; break; end
      end
      if (bad < 0) begin ok = 1; np = p; done = 1; end
      else if (p == MAXP) begin ok = 0; np = p; done = 1; end
      else begin s = bad; p++; end
    end
  endtask

  task automatic run_case(input string name, input bit poke_busy);
    int np, nr;
    bit ok;
    predict(np, ok, nr);
    pulses_seen = 0; reads_seen = 0; exp_addr = 0; prev_pulse = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && epulse && hv_sel && !pass && !fail, "R2 start accepted", {busy, epulse}, 3);
    if (poke_busy) begin
      repeat (PCYC / 2) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!pass && !fail) begin
      if (poke_busy && rd_valid) begin start = 1'b1; @(negedge clk); start = 1'b0; poke_busy = 0; end
      else @(negedge clk);
    end
    check(pass == ok, ok ? "R8 pass result" : "R9 fail result", pass, ok);
    check(pulses_seen == np, "R6 R9 pulse count", pulses_seen, np);
    check(reads_seen == nr, "R5 R7 read count", reads_seen, nr);
    check(!busy && !hv_sel && !epulse && !rd_valid, "R11 idle after end", {busy, hv_sel}, 0);
    repeat (3) @(negedge clk);
    check(pass == ok && fail == !ok, "R8 result held", pass, ok);
    if (name.len() == 0) $display("unnamed case");
  endtask

  task automatic fill(input int lo, input int hi);
    for (int a = 0; a < N; a++) begin
      need[a] = lo + ($urandom % (hi - lo + 1));
      miss[a] = 8'(1 + ($urandom % 255));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    mon_en = 0; pend = 0; hold_pend = 0; ready_pct = 100;
    repeat (3) @(negedge clk);
    check(!busy && !pass && !fail && !epulse && !rd_valid && !hv_sel, "R1 reset state",
          {busy, pass, fail, epulse, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1;
    // one pulse suffices everywhere
    fill(1, 1); run_case("single", 0);
    // top address slow: wrap on second sweep
    fill(1, 1); need[N-1] = 2; ready_pct = 60; run_case("wrap", 0);
    // only bit 7 clear on a slow byte
    fill(1, 1); need[7] = 3; miss[7] = 8'h80; run_case("bit7", 0);
    // exactly at the budget boundary: passes on the last pulse
    fill(1, 2); need[12] = MAXP; run_case("budget edge", 0);
    // one beyond budget: fail
    fill(1, 3); need[20] = MAXP + 1; run_case("budget over", 0);
    // start while busy is ignored
    fill(1, 3); ready_pct = 70; run_case("busy start", 1);
    // random mixes with back-pressure
    for (int r = 0; r < 6; r++) begin
      fill(1, 4); ready_pct = 30 + ($urandom % 70); run_case("random", 0);
    end
    finish_run();
  end
endmodule